// File: doc/BRIEF.md
# Multichannel Serial Audio Input Port

The block collects audio from up to eight serial receivers, each running on its own bit clock with its own frame sync and data line. The sync level splits a 64-bit frame into two 32-bit halves. Each receiver turns every complete half into one 32-bit word and passes it into the system clock domain through a toggle handshake. A round-robin arbiter moves the words into one shared FIFO, eight entries deep. Each entry carries the number of the channel it came from.

Channel 0 can be switched to a parallel acquisition path. That path samples up to 20 data bits on the rising edges of a slow acquisition clock and ignores those edges while a hold input is high. It packs the samples into 32-bit words in one of four ways.

A consumer pops entries with a read strobe. A word that arrives while the FIFO is full is thrown away and raises a sticky overflow flag, which stays high until the consumer clears it.

Top module: `ain_port`

## Requirements
- R1: After reset the FIFO reports empty=1 and full=0, and overflow=0.
- R2: With fmt=1 (left-justified) a word holds the first SAMPLE_W (24) bits after a sync transition, most significant bit first. They sit in bits 31:8 of the word and bits 7:0 are zero.
- R3: With fmt=0 (I2S) the sample starts one bit clock after the sync transition. The first bit after the transition belongs to the previous word. The word has the same left-aligned layout as in R2.
- R4: With fmt=2 (right-justified) the word holds the last 24 bits of the half, left-aligned the same way as in R2.
- R5: Bits received before the first sync transition after reset give no word. Every complete half after that gives exactly one word, so a 64-bit frame gives two words.
- R6: Words that complete in the same cycle enter the FIFO in ascending channel order, starting after the last channel granted. Each entry's rd_chan equals its channel index.
- R7: full=1 exactly when 8 entries are stored. rd_en while empty=1 has no effect.
- R8: A word arriving while the FIFO is full is dropped and the stored entries are kept. overflow goes to 1 and stays there until ovf_clr; a drop in the same cycle as ovf_clr wins.
- R9: With pack_mode=0 each sample becomes {data,12'b0}. With pack_mode=1 each sample becomes {12'b0,data}.
- R10: With pack_mode=2, data[19:4] of two samples form a word, the first in bits 31:16. With pack_mode=3, data[19:12] of four samples form a word, the first in bits 31:24.
- R11: A rising edge of par_clk while par_hold=1 captures nothing and does not advance the packing.
- R12: With par_en=1, channel 0 entries come only from the parallel path and serial channel 0 words are discarded. Parallel words carry tag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 2 | Serial framing: 0 I2S, 1 left-justified, 2 right-justified |
| par_en | input | 1 | Route the parallel path into channel 0 |
| pack_mode | input | 2 | Parallel packing mode 0..3 |
| ser_sclk | input | NUM_CH | Per-channel bit clocks |
| ser_fs | input | NUM_CH | Per-channel frame syncs |
| ser_sd | input | NUM_CH | Per-channel serial data |
| par_clk | input | 1 | Parallel acquisition clock |
| par_hold | input | 1 | Suppresses parallel capture while high |
| par_data | input | PAR_W | Parallel sample |
| rd_en | input | 1 | Pop the head entry |
| ovf_clr | input | 1 | Clear the overflow flag |
| rd_data | output | 32 | Head entry word |
| rd_chan | output | 3 | Head entry channel tag |
| fifo_full | output | 1 | FIFO holds 8 entries |
| fifo_empty | output | 1 | FIFO holds nothing |
| overflow | output | 1 | Sticky drop indicator |

## Verification
Two functions can fall in the same cycle. The first case is all eight receivers completing a word together. The bench drives every channel from one shared bit clock and sync, so all handshakes land in one system cycle, and it judges the FIFO order and the tags against a queue filled in channel order. The second case is a grant meeting a full FIFO. The consumer is stopped for two halves, and the bench then checks that only the first half's eight words come out and that overflow has risen and stays high until cleared.

// File: rtl/ain_pkg.sv
`timescale 1ns/1ps
package ain_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned TAG_W  = 3;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        PK_LEFT  = 2'd0,
        PK_RIGHT = 2'd1,
        PK_HALF  = 2'd2,
        PK_BYTE  = 2'd3
    } pack_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } entry_t;

    // index of the last piece that completes a packed word
    function automatic logic [1:0] last_piece(input pack_e m);
        case (m)
            PK_HALF: return 2'd1;
            PK_BYTE: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ain_ser_rx.sv
`timescale 1ns/1ps
module ain_ser_rx
    import ain_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  fmt_e              fmt,
    input  logic              sclk,
    input  logic              fs,
    input  logic              sd,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int unsigned PAD = WORD_W - SAMPLE_W;

    // ---------------- bit clock domain ----------------
    logic              rst_m, rst_s;
    logic              fs_q, fs_chg;
    logic [WORD_W-1:0] sr;
    logic              armed, dly, req_t, cap;
    logic              ack_m, ack_s;
    logic [WORD_W-1:0] hold_w;
    logic [SAMPLE_W-1:0] sample;

    // system side
    logic req_m, req_s, req_q;

    always_ff @(posedge sclk) begin
        rst_m <= rst;
        rst_s <= rst_m;
        fs_q  <= fs;
        sr    <= {sr[WORD_W-2:0], sd};
        ack_m <= req_q;
        ack_s <= ack_m;
    end

    always_comb begin
        fs_chg = fs ^ fs_q;
        cap    = (fs_chg && armed && fmt != FMT_I2S) || dly;
        sample = (fmt == FMT_RJ) ? sr[SAMPLE_W-1:0] : sr[WORD_W-1 -: SAMPLE_W];
    end

    always_ff @(posedge sclk) begin
        if (rst_s) begin
            armed  <= 1'b0;
            dly    <= 1'b0;
            req_t  <= 1'b0;
            hold_w <= '0;
        end else begin
            dly <= fs_chg && armed && (fmt == FMT_I2S);
            if (fs_chg)
                armed <= 1'b1;
            if (cap && (req_t == ack_s)) begin
                hold_w <= {sample, {PAD{1'b0}}};
                req_t  <= ~req_t;
            end
        end
    end

    // ---------------- system clock domain ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            req_m <= 1'b0;
            req_s <= 1'b0;
            req_q <= 1'b0;
        end else begin
            req_m <= req_t;
            req_s <= req_m;
            req_q <= req_s;
        end
    end

    assign valid_o = req_s ^ req_q;
    assign word_o  = hold_w;

    // R5: a handshake delivers each word once, never in back-to-back cycles
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

endmodule

// File: rtl/ain_par_pack.sv
`timescale 1ns/1ps
module ain_par_pack
    import ain_pkg::*;
#(
    parameter int unsigned PAR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  pack_e             mode,
    input  logic              pclk,
    input  logic              phold,
    input  logic [PAR_W-1:0]  pdata,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int unsigned PAD = WORD_W - PAR_W;

    logic             pclk_m, pclk_s, pclk_q;
    logic             hold_m, hold_s;
    logic [PAR_W-1:0] dat_m, dat_s;
    logic             take;
    logic [1:0]       cnt;
    logic [23:0]      acc;
    logic [WORD_W-1:0] nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_m <= 1'b0; pclk_s <= 1'b0; pclk_q <= 1'b0;
            hold_m <= 1'b0; hold_s <= 1'b0;
            dat_m  <= '0;   dat_s  <= '0;
        end else begin
            pclk_m <= pclk;  pclk_s <= pclk_m; pclk_q <= pclk_s;
            hold_m <= phold; hold_s <= hold_m;
            dat_m  <= pdata; dat_s  <= dat_m;
        end
    end

    always_comb begin
        take = pclk_s && !pclk_q && !hold_s;
        case (mode)
            PK_LEFT:  nxt = {dat_s, {PAD{1'b0}}};
            PK_RIGHT: nxt = {{PAD{1'b0}}, dat_s};
            PK_HALF:  nxt = {acc[15:0], dat_s[PAR_W-1 -: 16]};
            default:  nxt = {acc[23:0], dat_s[PAR_W-1 -: 8]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            acc     <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (take) begin
                acc <= nxt[23:0];
                if (cnt == last_piece(mode)) begin
                    word_o  <= nxt;
                    valid_o <= 1'b1;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 2'd1;
                end
            end
        end
    end

    // R11: a held acquisition clock produces no word
    p_hold_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        hold_s |=> !valid_o);

endmodule

// File: rtl/ain_rr_arb.sv
`timescale 1ns/1ps
module ain_rr_arb #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] ptr, nxt;
    logic             found;

    always_comb begin
        grant = '0;
        nxt   = ptr;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
                nxt        = IDX_W'((idx + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (found)
            ptr <= nxt;
    end

    // R6: one winner at most, and only among requesters
    p_grant_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    p_grant_in_req_r6: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

endmodule

// File: rtl/ain_fifo.sv
`timescale 1ns/1ps
module ain_fifo
    import ain_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  entry_t din,
    input  logic   pop,
    output entry_t dout,
    output logic   full,
    output logic   empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    entry_t          mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [CW-1:0]   cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                mem[wptr] <= din;
                wptr      <= step(wptr);
            end
            if (pop)
                rptr <= step(rptr);
            if (push && !pop)
                cnt <= cnt + CW'(1);
            else if (pop && !push)
                cnt <= cnt - CW'(1);
        end
    end

    assign dout  = mem[rptr];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // R8: the writer never pushes into a full store
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R7: the reader never pops an empty store
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/ain_port.sv
`timescale 1ns/1ps
module ain_port
    import ain_pkg::*;
#(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned SAMPLE_W   = 24,
    parameter int unsigned PAR_W      = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          fmt,
    input  logic                par_en,
    input  logic [1:0]          pack_mode,
    input  logic [NUM_CH-1:0]   ser_sclk,
    input  logic [NUM_CH-1:0]   ser_fs,
    input  logic [NUM_CH-1:0]   ser_sd,
    input  logic                par_clk,
    input  logic                par_hold,
    input  logic [PAR_W-1:0]    par_data,
    input  logic                rd_en,
    input  logic                ovf_clr,
    output logic [WORD_W-1:0]   rd_data,
    output logic [TAG_W-1:0]    rd_chan,
    output logic                fifo_full,
    output logic                fifo_empty,
    output logic                overflow
);
    logic [WORD_W-1:0] ser_w [NUM_CH];
    logic              ser_v [NUM_CH];
    logic [WORD_W-1:0] load_d [NUM_CH];
    logic              load_v [NUM_CH];
    logic [WORD_W-1:0] slot_d [NUM_CH];
    logic [NUM_CH-1:0] slot_v, grant;
    logic [WORD_W-1:0] par_w;
    logic              par_v;
    entry_t            win, head;
    logic              push, pop;

    ain_par_pack #(.PAR_W(PAR_W)) u_pack (
        .clk(clk), .rst(rst), .mode(pack_e'(pack_mode)),
        .pclk(par_clk), .phold(par_hold), .pdata(par_data),
        .word_o(par_w), .valid_o(par_v)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ain_ser_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
            .clk(clk), .rst(rst), .fmt(fmt_e'(fmt)),
            .sclk(ser_sclk[c]), .fs(ser_fs[c]), .sd(ser_sd[c]),
            .word_o(ser_w[c]), .valid_o(ser_v[c])
        );
        if (c == 0) begin : g_mux0
            assign load_v[c] = par_en ? par_v : ser_v[c];
            assign load_d[c] = par_en ? par_w : ser_w[c];
        end else begin : g_ser
            assign load_v[c] = ser_v[c];
            assign load_d[c] = ser_w[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v <= '0;
            for (int c = 0; c < NUM_CH; c++) slot_d[c] <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (load_v[c]) begin
                    slot_v[c] <= 1'b1;
                    slot_d[c] <= load_d[c];
                end else if (grant[c]) begin
                    slot_v[c] <= 1'b0;
                end
            end
        end
    end

    ain_rr_arb #(.N(NUM_CH)) u_arb (
        .clk(clk), .rst(rst), .req(slot_v), .grant(grant)
    );

    always_comb begin
        win = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (grant[c]) begin
                win.data = slot_d[c];
                win.tag  = TAG_W'(c);
            end
        end
    end

    assign push = (|grant) && !fifo_full;
    assign pop  = rd_en && !fifo_empty;

    ain_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(win), .pop(pop),
        .dout(head), .full(fifo_full), .empty(fifo_empty)
    );

    assign rd_data = head.data;
    assign rd_chan = head.tag;

    always_ff @(posedge clk) begin
        if (rst)
            overflow <= 1'b0;
        else if ((|grant) && fifo_full)
            overflow <= 1'b1;
        else if (ovf_clr)
            overflow <= 1'b0;
    end

    // R8: overflow holds until cleared, and a drop always raises it
    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (overflow && !ovf_clr) |=> overflow);
    p_drop_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
        ((|grant) && fifo_full) |=> overflow);

endmodule

// File: tb/ain_port_tb.sv
`timescale 1ns/1ps
module ain_port_tb_top;

    logic        clk = 1'b0;
    logic        sclk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt = 2'd1;
    logic        par_en = 1'b0;
    logic [1:0]  pack_mode = 2'd0;
    logic [7:0]  ser_fs = '0;
    logic [7:0]  ser_sd = '0;
    logic [7:0]  ser_sclk;
    logic        par_clk = 1'b0;
    logic        par_hold = 1'b0;
    logic [19:0] par_data = '0;
    logic        rd_en = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  rd_chan;
    logic        fifo_full, fifo_empty, overflow;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit rd_on = 1'b0;
    bit poke_rd = 1'b0;

    logic [31:0] exp_d [$];
    logic [2:0]  exp_c [$];
    int          exp_r [$];

    always #4 clk = ~clk;     // 125 MHz
    always #40 sclk = ~sclk;  // serial bit clock
    assign ser_sclk = {8{sclk}};

    ain_port dut_i (
        .clk(clk), .rst(rst), .fmt(fmt), .par_en(par_en), .pack_mode(pack_mode),
        .ser_sclk(ser_sclk), .ser_fs(ser_fs), .ser_sd(ser_sd),
        .par_clk(par_clk), .par_hold(par_hold), .par_data(par_data),
        .rd_en(rd_en), .ovf_clr(ovf_clr), .rd_data(rd_data), .rd_chan(rd_chan),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    function automatic string rname(input int r);
        return $sformatf("R%0d", r);
    endfunction

    task automatic push_exp(input logic [31:0] d, input logic [2:0] c, input int r);
        exp_d.push_back(d);
        exp_c.push_back(c);
        exp_r.push_back(r);
    endtask

    // consumer: compares each head entry with the model queue (R6 tags)
    initial begin
        forever begin
            @(negedge clk);
            if (rd_on && !fifo_empty) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R5 unexpected word", rd_data, 32'h0);
                end else begin
                    chk(rd_data == exp_d[0], rname(exp_r[0]), rd_data, exp_d[0]);
                    chk(rd_chan == exp_c[0], "R6 tag", 32'(rd_chan), 32'(exp_c[0]));
                    void'(exp_d.pop_front());
                    void'(exp_c.pop_front());
                    void'(exp_r.pop_front());
                end
                rd_en = 1'b1;
            end else begin
                rd_en = poke_rd;
            end
        end
    end

    task automatic do_reset(input logic [1:0] f, input bit pe, input logic [1:0] pm);
        @(negedge clk);
        rd_on = 1'b0;
        ser_fs = '0; ser_sd = '0; par_clk = 1'b0; par_hold = 1'b0;
        fmt = f; par_en = pe; pack_mode = pm;
        rst = 1'b1;
        repeat (60) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // sends nh data halves plus a trailing half; expects the first push_n halves
    task automatic serial_run(input logic [1:0] f, input int nh, input int push_n);
        logic [23:0] smp [8][8];
        logic [7:0]  jk  [8][8];
        logic [31:0] w, wp, tx;
        int r;
        r = (f == 2'd0) ? 3 : (f == 2'd2) ? 4 : 2;  // R3 / R4 / R2
        for (int c = 0; c < 8; c++)
            for (int h = 0; h < 8; h++) begin
                smp[c][h] = 24'($urandom);
                jk[c][h]  = 8'($urandom);
            end
        for (int h = 0; h < push_n; h++)
            for (int c = 0; c < 8; c++)
                if (!(par_en && c == 0)) push_exp({smp[c][h], 8'h00}, 3'(c), r);
        // R5: random bits before the first sync change must give nothing
        for (int b = 0; b < 8; b++) begin
            @(negedge sclk);
            ser_sd = 8'($urandom);
        end
        for (int h = 0; h <= nh; h++) begin
            for (int b = 0; b < 32; b++) begin
                @(negedge sclk);
                ser_fs = {8{(h % 2) == 0}};
                for (int c = 0; c < 8; c++) begin
                    w  = {smp[c][h], jk[c][h]};
                    wp = (h == 0) ? 32'h0 : {smp[c][h-1], jk[c][h-1]};
                    if (f == 2'd0)
                        ser_sd[c] = (b == 0) ? wp[0] : w[32-b];
                    else if (f == 2'd2) begin
                        tx = {jk[c][h], smp[c][h]};
                        ser_sd[c] = tx[31-b];
                    end else
                        ser_sd[c] = w[31-b];
                end
            end
        end
    endtask

    task automatic drain;
        rd_on = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (exp_d.size() == 0 && fifo_empty) break;
        end
        repeat (20) @(negedge clk);
        chk(exp_d.size() == 0, "R5 missing words", 32'(exp_d.size()), 32'h0);
        exp_d.delete(); exp_c.delete(); exp_r.delete();
    endtask

    task automatic par_sample(input logic [19:0] d, input bit hld);
        @(negedge clk);
        par_data = d; par_hold = hld;
        repeat (4) @(negedge clk);
        par_clk = 1'b1;
        repeat (4) @(negedge clk);
        par_clk = 1'b0;
        repeat (4) @(negedge clk);
        par_hold = 1'b0;
    endtask

    initial begin
        logic [19:0] a, b, c2, d2, x;
        void'($urandom(32'd2024));

        // R1: reset state
        do_reset(2'd1, 1'b0, 2'd0);
        chk(fifo_empty == 1'b1, "R1 empty", 32'(fifo_empty), 32'h1);
        chk(fifo_full == 1'b0, "R1 full", 32'(fifo_full), 32'h0);
        chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 32'h0);

        // R2 left-justified, R6 simultaneous completion order
        rd_on = 1'b1;
        serial_run(2'd1, 3, 3);
        drain();

        // R3 I2S
        do_reset(2'd0, 1'b0, 2'd0);
        rd_on = 1'b1;
        serial_run(2'd0, 3, 3);
        drain();

        // R4 right-justified
        do_reset(2'd2, 1'b0, 2'd0);
        rd_on = 1'b1;
        serial_run(2'd2, 3, 3);
        drain();

        // R8 / R7: consumer stopped, second half overflows
        do_reset(2'd1, 1'b0, 2'd0);
        serial_run(2'd1, 2, 1);
        repeat (20) @(negedge clk);
        chk(fifo_full == 1'b1, "R7 full at 8", 32'(fifo_full), 32'h1);
        chk(fifo_empty == 1'b0, "R7 not empty", 32'(fifo_empty), 32'h0);
        chk(overflow == 1'b1, "R8 overflow set", 32'(overflow), 32'h1);
        drain();
        chk(overflow == 1'b1, "R8 sticky", 32'(overflow), 32'h1);
        chk(fifo_empty == 1'b1, "R7 empty after drain", 32'(fifo_empty), 32'h1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        @(negedge clk);
        chk(overflow == 1'b0, "R8 cleared", 32'(overflow), 32'h0);

        // R7: reading an empty FIFO changes nothing
        rd_on = 1'b0;
        poke_rd = 1'b1;
        repeat (4) @(negedge clk);
        poke_rd = 1'b0;
        repeat (2) @(negedge clk);
        chk(fifo_empty == 1'b1 && fifo_full == 1'b0, "R7 empty read", {30'h0, fifo_full, fifo_empty}, 32'h1);
        rd_on = 1'b1;
        serial_run(2'd1, 1, 1);
        drain();

        // R12: parallel owns channel 0; R9 mode 0 with R11 hold
        do_reset(2'd1, 1'b1, 2'd0);
        rd_on = 1'b1;
        serial_run(2'd1, 2, 2);
        drain();
        a = 20'($urandom); b = 20'($urandom); x = 20'($urandom);
        push_exp({a, 12'h0}, 3'd0, 9);
        push_exp({b, 12'h0}, 3'd0, 9);
        par_sample(a, 1'b0);
        par_sample(x, 1'b1);   // R11: ignored
        par_sample(b, 1'b0);
        drain();

        // R9 mode 1
        do_reset(2'd1, 1'b1, 2'd1);
        a = 20'($urandom);
        push_exp({12'h0, a}, 3'd0, 9);
        rd_on = 1'b1;
        par_sample(a, 1'b0);
        drain();

        // R10 mode 2 with a held edge in between (R11)
        do_reset(2'd1, 1'b1, 2'd2);
        a = 20'($urandom); b = 20'($urandom); c2 = 20'($urandom); d2 = 20'($urandom); x = 20'($urandom);
        push_exp({a[19:4], b[19:4]}, 3'd0, 11);
        push_exp({c2[19:4], d2[19:4]}, 3'd0, 10);
        rd_on = 1'b1;
        par_sample(a, 1'b0);
        par_sample(x, 1'b1);
        par_sample(b, 1'b0);
        par_sample(c2, 1'b0);
        par_sample(d2, 1'b0);
        drain();

        // R10 mode 3
        do_reset(2'd1, 1'b1, 2'd3);
        a = 20'($urandom); b = 20'($urandom); c2 = 20'($urandom); d2 = 20'($urandom);
        push_exp({a[19:12], b[19:12], c2[19:12], d2[19:12]}, 3'd0, 10);
        rd_on = 1'b1;
        par_sample(a, 1'b0);
        par_sample(b, 1'b0);
        par_sample(c2, 1'b0);
        par_sample(d2, 1'b0);
        drain();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule